// File: doc/BRIEF.md
# Accumulator Subtract and Logic Unit with Status Flags

This block is the execute stage of an 8-bit accumulator datapath for four operations: plain subtract, subtract with borrow, bitwise AND and bitwise OR. The current accumulator value, an operand byte fetched from memory and the incoming carry flag come in on ports. A 2-bit select picks the operation. The result and a status flag byte are captured in registers on a clock edge where the write enable is high.

Each flag follows a rule that depends on the operation:

- **Arithmetic.** The half-borrow flag reports a borrow out of the low nibble. The parity/overflow flag reports signed overflow. The subtract flag is set.
- **Logic.** The half flag is a fixed value that differs between AND and OR. The parity/overflow flag reports even parity of the result. The subtract and carry flags are cleared.

Top module: `acc_alu_core`

## Requirements
- R1: With op = 2'b00 (subtract) and enable high, the accumulator register takes acc_in minus opnd modulo 256, and carry_in has no effect on the result.
- R2: With op = 2'b01 (subtract with borrow), the accumulator register takes acc_in minus opnd minus carry_in modulo 256.
- R3: With op = 2'b10 the result is acc_in AND opnd. With op = 2'b11 the result is acc_in OR opnd.
- R4: For every operation, flag bit 7 (sign) equals result bit 7, and flag bit 6 (zero) is set exactly when the 8-bit result is zero.
- R5: For both subtracts, flag bit 0 (carry) is set on a borrow out of bit 7, and flag bit 4 (half) is set on a borrow out of bit 3. Both borrows include carry_in for subtract with borrow, so 0x00 - 0xFF - 1 gives 0x00 with carry and half both set.
- R6: For both subtracts, flag bit 2 (parity/overflow) is set when the signed result falls outside -128..127, and flag bit 1 (subtract) is set.
- R7: For AND and OR, flag bits 1 (subtract) and 0 (carry) are cleared, and flag bit 2 is set when the result has an even number of one bits. Flag bit 4 is set for AND and cleared for OR.
- R8: Flag bits 5 and 3 always read zero.
- R9: When en is low, both acc_out and flags_out keep their values whatever the other inputs do.
- R10: A synchronous reset (rst high at a rising edge) clears acc_out and flags_out to zero, and it takes priority over en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Write enable for the accumulator and flag registers |
| op | input | 2 | Operation select: 00 subtract, 01 subtract with borrow, 10 AND, 11 OR |
| acc_in | input | 8 | Current accumulator value |
| opnd | input | 8 | Memory operand byte |
| carry_in | input | 1 | Current carry flag, used as the borrow in |
| acc_out | output | 8 | Registered result |
| flags_out | output | 8 | Registered flags: 7 S, 6 Z, 5 zero, 4 H, 3 zero, 2 P/V, 1 N, 0 C |

## Verification
A wrong borrow chain or flag selection shows up at the ports one edge after the enabled operation, as a wrong result byte or a wrong flag bit. The bench compares both against a reference built from integer arithmetic and bit counting after every enabled cycle. A wrong borrow-in path shows only for subtract with borrow when carry_in is set. For that reason the random mix drives both carry values, and directed cases cover the double-borrow corner and both signed-overflow directions. A register that drifts while the enable is low appears as a changed output during hold cycles, which are checked directly.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int unsigned FLAG_W = 8;

    // Flag byte bit positions
    localparam int unsigned FLG_S  = 7;
    localparam int unsigned FLG_Z  = 6;
    localparam int unsigned FLG_X5 = 5;
    localparam int unsigned FLG_H  = 4;
    localparam int unsigned FLG_X3 = 3;
    localparam int unsigned FLG_PV = 2;
    localparam int unsigned FLG_N  = 1;
    localparam int unsigned FLG_C  = 0;

    typedef enum logic [1:0] {
        OP_SUB = 2'b00,
        OP_SBC = 2'b01,
        OP_AND = 2'b10,
        OP_OR  = 2'b11
    } alu_op_e;

endpackage

// File: rtl/acc_alu_subtract.sv
module acc_alu_subtract #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    input  logic              borrow_in,
    output logic [DATA_W-1:0] diff,
    output logic              half_borrow,
    output logic              full_borrow,
    output logic              overflow
);
    localparam int unsigned LOW_W = DATA_W / 2;

    logic [LOW_W:0]  low_d;
    logic [DATA_W:0] full_d;

    always_comb begin
        low_d  = {1'b0, minuend[LOW_W-1:0]} - {1'b0, subtrahend[LOW_W-1:0]}
                 - {{LOW_W{1'b0}}, borrow_in};
        full_d = {1'b0, minuend} - {1'b0, subtrahend}
                 - {{DATA_W{1'b0}}, borrow_in};
        diff        = full_d[DATA_W-1:0];
        half_borrow = low_d[LOW_W];
        full_borrow = full_d[DATA_W];
        overflow    = (minuend[DATA_W-1] != subtrahend[DATA_W-1]) &&
                      (full_d[DATA_W-1] != minuend[DATA_W-1]);
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  logic              sel_or,
    output logic [DATA_W-1:0] res,
    output logic              even_par
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign res[i] = sel_or ? (lhs[i] | rhs[i]) : (lhs[i] & rhs[i]);
    end

    assign even_par = ~(^res);
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] res,
    input  logic              half_borrow,
    input  logic              full_borrow,
    input  logic              overflow,
    input  logic              even_par,
    output logic [FLAG_W-1:0] flags
);
    logic is_logic;

    always_comb begin
        is_logic       = (op == OP_AND) || (op == OP_OR);
        flags          = '0;
        flags[FLG_S]   = res[DATA_W-1];
        flags[FLG_Z]   = (res == '0);
        flags[FLG_X5]  = 1'b0;
        flags[FLG_X3]  = 1'b0;
        if (is_logic) begin
            flags[FLG_H]  = (op == OP_AND);
            flags[FLG_PV] = even_par;
            flags[FLG_N]  = 1'b0;
            flags[FLG_C]  = 1'b0;
        end else begin
            flags[FLG_H]  = half_borrow;
            flags[FLG_PV] = overflow;
            flags[FLG_N]  = 1'b1;
            flags[FLG_C]  = full_borrow;
        end
    end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        op,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd,
    input  logic              carry_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [FLAG_W-1:0] flags_out
);
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [FLAG_W-1:0] flg;
    } state_t;

    state_t state_d, state_q;
    alu_op_e op_sel;

    logic [DATA_W-1:0] sub_res, log_res, res_mux;
    logic              sub_hb, sub_fb, sub_ov, log_even, borrow_eff;
    logic [FLAG_W-1:0] flg_new;

    assign op_sel     = alu_op_e'(op);
    assign borrow_eff = (op_sel == OP_SBC) ? carry_in : 1'b0;

    acc_alu_subtract #(.DATA_W(DATA_W)) i_sub (
        .minuend     (acc_in),
        .subtrahend  (opnd),
        .borrow_in   (borrow_eff),
        .diff        (sub_res),
        .half_borrow (sub_hb),
        .full_borrow (sub_fb),
        .overflow    (sub_ov)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) i_logic (
        .lhs      (acc_in),
        .rhs      (opnd),
        .sel_or   (op_sel == OP_OR),
        .res      (log_res),
        .even_par (log_even)
    );

    assign res_mux = op[1] ? log_res : sub_res;

    acc_alu_flags #(.DATA_W(DATA_W)) i_flags (
        .op          (op_sel),
        .res         (res_mux),
        .half_borrow (sub_hb),
        .full_borrow (sub_fb),
        .overflow    (sub_ov),
        .even_par    (log_even),
        .flags       (flg_new)
    );

    always_comb begin
        state_d = state_q;
        if (en) begin
            state_d.acc = res_mux;
            state_d.flg = flg_new;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign acc_out   = state_q.acc;
    assign flags_out = state_q.flg;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [1:0]        op,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd,
    input logic [DATA_W-1:0] acc_out,
    input logic [7:0]        flags_out
);
    AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b00) |=> acc_out == $past(acc_in - opnd)); // R1
    AST_LOGIC_RESULT: assert property (@(posedge clk) disable iff (rst)
        (en && op == 2'b10) |=> acc_out == $past(acc_in & opnd)); // R3
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        en |=> (flags_out[7] == acc_out[7]) && (flags_out[6] == (acc_out == '0))); // R4
    AST_SUB_NFLAG: assert property (@(posedge clk) disable iff (rst)
        (en && !op[1]) |=> flags_out[1]); // R6
    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (en && op[1]) |=> !flags_out[1] && !flags_out[0] && (flags_out[2] == ~(^acc_out))
                          && (flags_out[4] == !$past(op[0]))); // R7
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        en |=> !flags_out[5] && !flags_out[3]); // R8
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_out) && $stable(flags_out)); // R9
endmodule

bind acc_alu_core acc_alu_checker #(.DATA_W(DATA_W)) i_acc_alu_checker (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .op        (op),
    .acc_in    (acc_in),
    .opnd      (opnd),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/test_acc_alu_core.sv
module test_acc_alu_core;
    logic       clk = 1'b0;
    logic       rst, en, carry_in;
    logic [1:0] op;
    logic [7:0] acc_in, opnd, acc_out, flags_out;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    acc_alu_core i_acc_alu_core (
        .clk(clk), .rst(rst), .en(en), .op(op), .acc_in(acc_in), .opnd(opnd),
        .carry_in(carry_in), .acc_out(acc_out), .flags_out(flags_out)
    );

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += int'(v[i]);
        return n;
    endfunction

    // Returns {result, flags}
    function automatic logic [15:0] model(input logic [1:0] o, input logic [7:0] a,
                                          input logic [7:0] b, input logic c);
        int cb, r, lo, sr;
        logic [7:0] res, f;
        f = 8'h00;
        if (o[1] == 1'b0) begin
            cb = (o == 2'b01) ? int'(c) : 0;
            r  = int'(a) - int'(b) - cb;
            lo = int'(a % 16) - int'(b % 16) - cb;
            sr = int'($signed(a)) - int'($signed(b)) - cb;
            res = 8'(r);
            f[0] = (r < 0);
            f[4] = (lo < 0);
            f[2] = (sr < -128) || (sr > 127);
            f[1] = 1'b1;
        end else begin
            res  = o[0] ? (a | b) : (a & b);
            f[4] = !o[0];
            f[2] = (ones(res) % 2 == 0);
        end
        f[7] = res[7];
        f[6] = (res == 8'h00);
        return {res, f};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [7:0] a, input logic [7:0] b,
                          input logic c);
        logic [15:0] e;
        e = model(o, a, b, c);
        @(negedge clk);
        en = 1'b1; op = o; acc_in = a; opnd = b; carry_in = c;
        @(negedge clk);
        en = 1'b0;
        case (o)
            2'b00: chk("R1 sub result", acc_out, e[15:8]);
            2'b01: chk("R2 sbc result", acc_out, e[15:8]);
            default: chk("R3 logic result", acc_out, e[15:8]);
        endcase
        chk("R4 sign/zero", flags_out & 8'hC0, e[7:0] & 8'hC0);
        if (!o[1]) begin
            chk("R5 half/carry borrow", flags_out & 8'h11, e[7:0] & 8'h11);
            chk("R6 overflow/N", flags_out & 8'h06, e[7:0] & 8'h06);
        end else begin
            chk("R7 logic flags", flags_out & 8'h17, e[7:0] & 8'h17);
        end
        chk("R8 fixed zero bits", flags_out & 8'h28, 8'h00);
    endtask

    initial begin
        logic [7:0] ha, hf;
        void'($urandom(32'd1234));
        rst = 1'b1; en = 1'b0; op = 2'b00; acc_in = 8'h00; opnd = 8'h00; carry_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 reset acc", acc_out, 8'h00);
        chk("R10 reset flags", flags_out, 8'h00);
        rst = 1'b0;

        // Directed corners
        run_op(2'b01, 8'h00, 8'hFF, 1'b1); // R5 double borrow
        run_op(2'b00, 8'h80, 8'h01, 1'b1); // R6 overflow, R1 carry ignored
        run_op(2'b00, 8'h7F, 8'hFF, 1'b0); // R6 overflow other direction
        run_op(2'b00, 8'h10, 8'h01, 1'b0); // R5 half borrow only
        run_op(2'b01, 8'h55, 8'h55, 1'b0); // R4 zero
        run_op(2'b10, 8'hF0, 8'h0F, 1'b0); // R7 AND zero result
        run_op(2'b11, 8'h00, 8'h00, 1'b1); // R7 OR zero
        run_op(2'b11, 8'h80, 8'h01, 1'b1); // R7 OR even parity
        run_op(2'b10, 8'h07, 8'hFF, 1'b0); // R7 AND odd parity

        // Random mix
        for (int k = 0; k < 400; k++)
            run_op(2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));

        // R9 hold with enable low
        run_op(2'b00, 8'h3C, 8'h0A, 1'b0);
        ha = acc_out; hf = flags_out;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            en = 1'b0; op = 2'($urandom); acc_in = 8'($urandom); opnd = 8'($urandom);
            carry_in = 1'($urandom);
            @(negedge clk);
            chk("R9 hold acc", acc_out, ha);
            chk("R9 hold flags", flags_out, hf);
        end

        // R10 reset wins over enable
        run_op(2'b00, 8'h00, 8'h01, 1'b0);
        @(negedge clk);
        rst = 1'b1; en = 1'b1; op = 2'b11; acc_in = 8'hFF; opnd = 8'hFF;
        @(negedge clk);
        chk("R10 reset over enable acc", acc_out, 8'h00);
        chk("R10 reset over enable flags", flags_out, 8'h00);
        rst = 1'b0; en = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule